// File: doc/BRIEF.md
# Loop Supervision and Ring-Trip Controller

This block turns the raw output of a loop-current comparator into a clean switch-hook indication for a line card. The comparator bit reads 1 when the loop resistance is low enough to mean that a handset is lifted. The block retimes this bit and qualifies it against a tick-paced window. It then drives an active-low hook output and an identical active-low LED output. It also gates the ring relay drive that software requests through a command bit.

While ringing is applied, a longer qualification window acts as a ringing filter. The AC ringing current and the transients from switching the relay then cannot look like an answer. A confirmed answer during ringing trips the ring relay off, even though the command bit is still set. The trip holds until software drops the command. After ringing ends, a short blanking period hides the release transient of the relay. Outside ringing the window stays short, so dial pulses pass through to the hook output.

Top module: `hook_supervisor`

## Requirements
- R1: After a synchronous reset the block is on-hook and idle: `shkN` = 1, `ledN` = 1, `ringRelay` = 0.
- R2: Outside ringing, a change of `loopDet` becomes a change of `shkN` only after the new level has persisted through `HOOK_TICKS` consecutive ticks, in both directions. A shorter excursion leaves `shkN` unchanged. `loopDet` = 1 means off-hook and `shkN` = 0 means off-hook.
- R3: `ledN` always equals `shkN`.
- R4: A rising edge of `ringCmd` while the line is idle on-hook starts ringing, so `ringRelay` = 1. `ringRelay` falls in the same cycle in which `ringCmd` falls.
- R5: While ringing, `loopDet` must stay 1 through `TRIP_TICKS` consecutive ticks before an off-hook is accepted, with `TRIP_TICKS` >= `HOOK_TICKS`. Any shorter bursts of 1 leave `shkN` = 1 and `ringRelay` = 1.
- R6: An accepted off-hook during ringing drives `ringRelay` to 0 and `shkN` to 0 while `ringCmd` is still 1.
- R7: After a trip, `ringRelay` stays 0 until `ringCmd` has been cleared and raised again while the line is idle on-hook. A rising edge of `ringCmd` while off-hook never starts ringing.
- R8: When ringing ends, changes of `loopDet` are ignored for `BLANK_TICKS` ticks. Qualification restarts only after that.
- R9: Dial pulses, meaning breaks and makes each longer than `HOOK_TICKS` ticks, appear one for one on `shkN` when the line is not ringing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle timing pulse (nominally 1 ms) |
| loopDet | input | 1 | Raw loop comparator, 1 = low loop resistance (off-hook) |
| ringCmd | input | 1 | Ring relay command from the control register |
| shkN | output | 1 | Debounced switch-hook, 0 = off-hook |
| ledN | output | 1 | LED drive, same as shkN |
| ringRelay | output | 1 | Gated ring relay driver, 1 = relay energised |

## Verification
The hardest case to reach is the blanking window after ringing is removed. Its effect shows only when the detector moves in exactly the ticks after the relay releases. The stimulus therefore drops `ringCmd` and raises `loopDet` on the same cycle. It holds the detector for more ticks than the idle window but fewer than the blanking and idle windows together, so the off-hook would be taken only if blanking were missing. The trip latch also takes a planned sequence. The line is answered during ringing and then kept off-hook with the command still high. The command is then toggled while off-hook, and finally the line is hung up with the command still set. At each step the relay must stay off.

// File: rtl/hook_sup_pkg.sv
package hook_sup_pkg;

  typedef enum logic [1:0] {
    S_IDLE_ONHOOK = 2'd0,
    S_OFFHOOK     = 2'd1,
    S_RINGING     = 2'd2,
    S_TRIPPED     = 2'd3
  } hookState_t;

  // control -> datapath
  typedef struct packed {
    logic refOffHook;   // currently reported hook level (1 = off-hook)
    logic ringWindow;   // select the long ringing qualification window
    logic blankStart;   // ringing is ending: load the blanking timer
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic qualify;      // detector differs from reported level for a full window
    logic ringRise;     // rising edge of the ring command
    logic blanking;     // release blanking in progress
  } dpStatus_t;

endpackage

// File: rtl/hook_sup_dp.sv
module hook_sup_dp
  import hook_sup_pkg::*;
#(
  parameter int HOOK_TICKS  = 20,
  parameter int TRIP_TICKS  = 80,
  parameter int BLANK_TICKS = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        loopDet,
  input  logic        ringCmd,
  input  ctrlStrobe_t strobe,
  output dpStatus_t   status
);

  localparam int MAX_WIN = (TRIP_TICKS > HOOK_TICKS) ? TRIP_TICKS : HOOK_TICKS;
  localparam int CNT_W   = $clog2(MAX_WIN + 1);
  localparam int BLK_W   = $clog2(BLANK_TICKS + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   detSync;
  logic                   ringCmdQ;
  logic [CNT_W-1:0]       qualCnt;
  logic [CNT_W-1:0]       winLimit;
  logic [BLK_W-1:0]       blankCnt;
  logic                   mismatch;
  logic                   blanking;
  logic                   qualify;

  // retiming chain for the asynchronous comparator bit
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) syncQ <= '0;
        else     syncQ <= loopDet;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (rst) syncQ <= '0;
        else     syncQ <= {syncQ[SYNC_STAGES-2:0], loopDet};
      end
    end
  endgenerate

  assign detSync = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) ringCmdQ <= 1'b0;
    else     ringCmdQ <= ringCmd;
  end

  assign winLimit = strobe.ringWindow ? CNT_W'(TRIP_TICKS) : CNT_W'(HOOK_TICKS);
  assign mismatch = (detSync != strobe.refOffHook);
  assign blanking = (blankCnt != '0);
  assign qualify  = tick && mismatch && !blanking && (qualCnt == winLimit - CNT_W'(1));

  // consecutive-tick qualification counter
  always_ff @(posedge clk) begin
    if (rst)
      qualCnt <= '0;
    else if (!mismatch || blanking || qualify || strobe.blankStart)
      qualCnt <= '0;
    else if (tick)
      qualCnt <= qualCnt + CNT_W'(1);
  end

  // relay release blanking timer
  always_ff @(posedge clk) begin
    if (rst)
      blankCnt <= '0;
    else if (strobe.blankStart)
      blankCnt <= BLK_W'(BLANK_TICKS);
    else if (tick && blanking)
      blankCnt <= blankCnt - BLK_W'(1);
  end

  assign status.qualify  = qualify;
  assign status.ringRise = ringCmd && !ringCmdQ;
  assign status.blanking = blanking;

  // R2 R5: the window counter never reaches the active limit
  a_r5_window_bound: assert property (@(posedge clk) disable iff (rst)
    qualCnt < winLimit);

  // R8: a blanking period ends only through its ticks
  a_r8_blank_steps: assert property (@(posedge clk) disable iff (rst)
    (blanking && !tick && !strobe.blankStart) |=> $stable(blankCnt));

endmodule

// File: rtl/hook_sup_ctrl.sv
module hook_sup_ctrl
  import hook_sup_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        ringCmd,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        shkN,
  output logic        ledN,
  output logic        ringRelay
);

  hookState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE_ONHOOK: begin
        if (status.qualify)       stateNext = S_OFFHOOK;
        else if (status.ringRise) stateNext = S_RINGING;
      end
      S_OFFHOOK: begin
        if (status.qualify)       stateNext = S_IDLE_ONHOOK;
      end
      S_RINGING: begin
        if (!ringCmd)             stateNext = S_IDLE_ONHOOK;
        else if (status.qualify)  stateNext = S_TRIPPED;
      end
      S_TRIPPED: begin
        if (status.qualify)       stateNext = S_IDLE_ONHOOK;
        else if (!ringCmd)        stateNext = S_OFFHOOK;
      end
      default:                    stateNext = S_IDLE_ONHOOK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE_ONHOOK;
    else     state <= stateNext;
  end

  assign strobe.refOffHook = (state == S_OFFHOOK) || (state == S_TRIPPED);
  assign strobe.ringWindow = (state == S_RINGING);
  assign strobe.blankStart = (state == S_RINGING) && (stateNext != S_RINGING);

  assign shkN      = !strobe.refOffHook;
  assign ledN      = shkN;
  assign ringRelay = (state == S_RINGING) && ringCmd;

  // R6: the relay is never energised while off-hook is reported
  a_r6_no_ring_offhook: assert property (@(posedge clk) disable iff (rst)
    !shkN |-> !ringRelay);

  // R6: the tripped state is reached only from ringing
  a_r6_trip_from_ring: assert property (@(posedge clk) disable iff (rst)
    (state == S_TRIPPED && $past(state) != S_TRIPPED) |-> $past(state) == S_RINGING);

  // R7: ringing starts only from the idle on-hook state
  a_r7_ring_from_idle: assert property (@(posedge clk) disable iff (rst)
    (state == S_RINGING && $past(state) != S_RINGING) |-> $past(state) == S_IDLE_ONHOOK);

  // R8: the hook output holds during a blanking period
  a_r8_blank_holds_hook: assert property (@(posedge clk) disable iff (rst)
    (status.blanking && $past(status.blanking)) |-> $stable(shkN));

  // R3: the LED output tracks the hook output
  a_r3_led_tracks: assert property (@(posedge clk) disable iff (rst)
    ledN == shkN);

endmodule

// File: rtl/hook_supervisor.sv
module hook_supervisor
  import hook_sup_pkg::*;
#(
  parameter int HOOK_TICKS  = 20,
  parameter int TRIP_TICKS  = 80,
  parameter int BLANK_TICKS = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic loopDet,
  input  logic ringCmd,
  output logic shkN,
  output logic ledN,
  output logic ringRelay
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  hook_sup_dp #(
    .HOOK_TICKS (HOOK_TICKS),
    .TRIP_TICKS (TRIP_TICKS),
    .BLANK_TICKS(BLANK_TICKS),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_dp (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .loopDet(loopDet),
    .ringCmd(ringCmd),
    .strobe (strobe),
    .status (status)
  );

  hook_sup_ctrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .ringCmd  (ringCmd),
    .status   (status),
    .strobe   (strobe),
    .shkN     (shkN),
    .ledN     (ledN),
    .ringRelay(ringRelay)
  );

  initial begin
    assert (HOOK_TICKS >= 1 && TRIP_TICKS >= HOOK_TICKS && BLANK_TICKS >= 1 && SYNC_STAGES >= 1)
      else $error("hook_supervisor: illegal parameter set");
  end

endmodule

// File: tb/test_hook_supervisor.sv
module test_hook_supervisor;

  localparam int CLK_PERIOD = 10;
  localparam int TD         = 4;   // cycles per tick
  localparam int HOOK       = 5;
  localparam int TRIP       = 12;
  localparam int BLANK      = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic loopDet = 1'b0;
  logic ringCmd = 1'b0;
  logic shkN, ledN, ringRelay;

  int checks = 0;
  int errors = 0;
  int tickDiv = 0;

  logic [1:0] expQ[$];
  string      tagQ[$];
  logic [1:0] prevOut;

  hook_supervisor #(
    .HOOK_TICKS(HOOK), .TRIP_TICKS(TRIP), .BLANK_TICKS(BLANK), .SYNC_STAGES(2)
  ) i_hook_supervisor (
    .clk(clk), .rst(rst), .tick(tick), .loopDet(loopDet), .ringCmd(ringCmd),
    .shkN(shkN), .ledN(ledN), .ringRelay(ringRelay)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tickDiv = (tickDiv == TD-1) ? 0 : tickDiv + 1;
    tick = (tickDiv == 0);
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic expectOut(input logic expShk, input logic expRelay, input string tag);
    expQ.push_back({expShk, expRelay});
    tagQ.push_back(tag);
  endtask

  task automatic waitTicks(input int n);
    repeat (n*TD) @(negedge clk);
  endtask

  // monitor: every change of {shkN, ringRelay} is matched against the queue
  always begin
    @(posedge clk);
    #1;
    if (rst) begin
      prevOut = {shkN, ringRelay};
    end else if ({shkN, ringRelay} != prevOut) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected output change", int'({shkN, ringRelay}), int'(prevOut));
      end else begin
        logic [1:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check({shkN, ringRelay} == e, t, int'({shkN, ringRelay}), int'(e));
      end
      check(ledN == shkN, "R3 led follows hook", int'(ledN), int'(shkN));
      prevOut = {shkN, ringRelay};
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (6) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(shkN == 1'b1, "R1 shkN after reset", int'(shkN), 1);
    check(ledN == 1'b1, "R1 ledN after reset", int'(ledN), 1);
    check(ringRelay == 1'b0, "R1 ringRelay after reset", int'(ringRelay), 0);

    // R2 short glitch is rejected
    loopDet = 1'b1;
    waitTicks(3);
    loopDet = 1'b0;
    waitTicks(8);
    check(shkN == 1'b1, "R2 glitch rejected", int'(shkN), 1);

    // R2 off-hook onset timing
    expectOut(1'b0, 1'b0, "R2 off-hook accepted");
    loopDet = 1'b1;
    waitTicks(HOOK-2);
    check(shkN == 1'b1, "R2 off-hook not early", int'(shkN), 1);
    waitTicks(4);
    check(shkN == 1'b0, "R2 off-hook on time", int'(shkN), 0);
    check(ledN == 1'b0, "R3 led low off-hook", int'(ledN), 0);

    // R9 dial pulses
    for (int p = 0; p < 2; p++) begin
      expectOut(1'b1, 1'b0, "R9 dial break");
      expectOut(1'b0, 1'b0, "R9 dial make");
      loopDet = 1'b0;
      waitTicks(8);
      check(shkN == 1'b1, "R9 break seen", int'(shkN), 1);
      loopDet = 1'b1;
      waitTicks(8);
      check(shkN == 1'b0, "R9 make seen", int'(shkN), 0);
    end

    // R2 on-hook release timing
    expectOut(1'b1, 1'b0, "R2 on-hook accepted");
    loopDet = 1'b0;
    waitTicks(HOOK-2);
    check(shkN == 1'b0, "R2 on-hook not early", int'(shkN), 0);
    waitTicks(4);
    check(shkN == 1'b1, "R2 on-hook on time", int'(shkN), 1);

    // R4 ringing starts on rising command edge
    expectOut(1'b1, 1'b1, "R4 ringing starts");
    ringCmd = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(ringRelay == 1'b1, "R4 relay on", int'(ringRelay), 1);

    // R5 ringing current bursts longer than the idle window are filtered
    for (int b = 0; b < 3; b++) begin
      loopDet = 1'b1;
      waitTicks(8);
      loopDet = 1'b0;
      waitTicks(2);
    end
    check(shkN == 1'b1, "R5 no false off-hook", int'(shkN), 1);
    check(ringRelay == 1'b1, "R5 ringing kept", int'(ringRelay), 1);

    // R6 ring trip
    expectOut(1'b0, 1'b0, "R6 ring trip");
    loopDet = 1'b1;
    waitTicks(TRIP-2);
    check(ringRelay == 1'b1, "R5 trip not early", int'(ringRelay), 1);
    waitTicks(4);
    check(ringRelay == 1'b0, "R6 relay off with command set", int'(ringRelay), 0);
    check(shkN == 1'b0, "R6 off-hook reported", int'(shkN), 0);

    // R7 trip latch and re-arm rules
    waitTicks(30);
    check(ringRelay == 1'b0, "R7 trip latched", int'(ringRelay), 0);
    ringCmd = 1'b0;
    waitTicks(3);
    ringCmd = 1'b1;
    waitTicks(3);
    check(ringRelay == 1'b0, "R7 no ringing when off-hook", int'(ringRelay), 0);
    expectOut(1'b1, 1'b0, "R7 hang-up with command high");
    loopDet = 1'b0;
    waitTicks(8);
    check(shkN == 1'b1, "R7 on-hook seen", int'(shkN), 1);
    check(ringRelay == 1'b0, "R7 needs a new edge", int'(ringRelay), 0);
    ringCmd = 1'b0;
    waitTicks(2);
    expectOut(1'b1, 1'b1, "R7 re-armed");
    ringCmd = 1'b1;
    waitTicks(2);
    check(ringRelay == 1'b1, "R7 ringing again", int'(ringRelay), 1);

    // R8 blanking after ringing removal; R4 immediate relay release
    expectOut(1'b1, 1'b0, "R4 relay release");
    ringCmd = 1'b0;
    loopDet = 1'b1;
    @(negedge clk);
    check(ringRelay == 1'b0, "R4 relay follows command", int'(ringRelay), 0);
    waitTicks(7);
    loopDet = 1'b0;
    waitTicks(10);
    check(shkN == 1'b1, "R8 release transient ignored", int'(shkN), 1);

    // R8 detection resumes after blanking
    expectOut(1'b0, 1'b0, "R8 detection resumes");
    loopDet = 1'b1;
    waitTicks(8);
    check(shkN == 1'b0, "R8 off-hook after blanking", int'(shkN), 0);

    waitTicks(2);
    check(expQ.size() == 0, "R2 all expected changes seen", expQ.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule